// File: doc/BRIEF.md
# Entropy bitstream health test monitor

This block watches a serial stream of raw one-bit noise samples and judges whether the source behind them is healthy. Each sample arrives with a valid strobe. Three statistical tests run on every valid sample:
- a repetition test, which flags an over-long run of one value;
- an adaptive proportion test, which flags a window in which the window's first value is too common;
- a transition test, which flags an over-long stretch of strict alternation.

After reset or restart the block is in a startup phase. This phase lasts a set number of complete proportion windows. If no test fires during it, the startup-done output rises and the stream may be used. If any test fires during startup, the startup-fail output rises and startup-done stays low. Once startup has passed, the same tests keep running. Any later hit raises the continuous-fail output. Both failure flags are sticky until a restart. The restart input clears every counter and flag and runs the whole startup phase again.

All thresholds and the window length are parameters. The defaults are a run limit of 42, a window of 1024 samples, a proportion limit of 711 and an alternation limit of 32.

Top module: `entropy_health_mon`

## Requirements
- R1: While reset (rst_n low) or restart is applied, and on the first clock after either, startup_done, startup_fail and cont_fail are all 0.
- R2: A valid sample fails the repetition test when it makes the current run of identical consecutive valid samples longer than REP_LIMIT. A run of exactly REP_LIMIT does not fail. The run starts at length 1 on the first sample after restart and on any sample that differs from the previous one.
- R3: Valid samples are grouped into consecutive windows of APT_WIN samples. The first sample of a window sets the reference value. A sample fails the proportion test when it brings the count of reference-valued samples in the current window, the first sample included, above APT_LIMIT. A count of exactly APT_LIMIT does not fail.
- R4: The transition count is 0 after restart. It rises by 1 on each valid sample that differs from the previous valid sample and returns to 0 on a sample equal to the previous one. A sample fails the transition test when it makes this count exceed TRN_LIMIT.
- R5: startup_done rises one clock after the valid sample that completes STARTUP_WINDOWS full windows, provided no test has fired since restart. It is 0 before that sample is taken.
- R6: A test hit during startup sets startup_fail. startup_fail then stays 1 and startup_done stays 0 until restart or reset.
- R7: A test hit after startup has passed sets cont_fail. cont_fail stays 1 until restart or reset. startup_done stays 1 and startup_fail stays 0.
- R8: Cycles with sample_vld low change no test state and no output. A run, a window or an alternation stretch continues across them.
- R9: Restart clears all test state. The next valid sample starts a new run, a new window and a new startup phase.
- R10: A failure flag rises on the clock edge that takes the offending sample. It is 0 before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear and rerun of the startup phase |
| sample_vld | input | 1 | Qualifies sample_bit on this cycle |
| sample_bit | input | 1 | Raw noise sample |
| startup_done | output | 1 | Startup phase completed with no test hit |
| startup_fail | output | 1 | A test fired during startup (sticky) |
| cont_fail | output | 1 | A test fired after startup passed (sticky) |

## Verification
A wrong internal counter shows at the ports as a failure flag that rises one sample too early or too late at a threshold boundary. It can also show as a flag that never rises. This appears on the clock edge that takes the boundary sample, so the bench drives each test to exactly its limit and then one sample past it. A wrong window position or window count moves the rising edge of startup_done away from the clock after the last startup sample. Stale state left by a restart shows as a spurious hit in the next startup phase. Counting across idle cycles shows as a different fail point when the stream is interleaved with idle cycles.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

  typedef enum logic [1:0] {
    PH_STARTUP = 2'd0,
    PH_PASSED  = 2'd1,
    PH_FAILED  = 2'd2
  } phase_e;

  // Next length of a run: grows by one when extended (saturating at cap),
  // otherwise restarts at base.
  function automatic int unsigned run_next(int unsigned cur, logic extend,
                                           int unsigned base, int unsigned cap);
    if (!extend) return base;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

  // True when a counter value breaks its limit.
  function automatic logic over_limit(int unsigned value, int unsigned limit);
    return value > limit;
  endfunction

endpackage

// File: rtl/ehm_rep_test.sv
module ehm_rep_test
  import ehm_pkg::*;
#(
  parameter int unsigned LIMIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic bit_in,
  input  logic prev_bit,
  input  logic have_prev,
  output logic hit
);
  localparam int unsigned CAP = LIMIT + 1;
  localparam int W = $clog2(CAP + 1);

  logic [W-1:0] run_q, run_d;

  always_comb begin
    run_d = W'(run_next(32'(run_q), have_prev && (bit_in == prev_bit), 1, CAP));
    hit   = vld && over_limit(32'(run_d), LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (clr) run_q <= '0;
    else if (vld) run_q <= run_d;
  end
endmodule

// File: rtl/ehm_trn_test.sv
module ehm_trn_test
  import ehm_pkg::*;
#(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic bit_in,
  input  logic prev_bit,
  input  logic have_prev,
  output logic hit
);
  localparam int unsigned CAP = LIMIT + 1;
  localparam int W = $clog2(CAP + 1);

  logic [W-1:0] alt_q, alt_d;

  always_comb begin
    alt_d = W'(run_next(32'(alt_q), have_prev && (bit_in != prev_bit), 0, CAP));
    hit   = vld && over_limit(32'(alt_d), LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   alt_q <= '0;
    else if (clr) alt_q <= '0;
    else if (vld) alt_q <= alt_d;
  end
endmodule

// File: rtl/ehm_apt_test.sv
module ehm_apt_test
  import ehm_pkg::*;
#(
  parameter int unsigned WIN   = 1024,
  parameter int unsigned LIMIT = 711
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic bit_in,
  output logic hit,
  output logic win_end
);
  localparam int PW = $clog2(WIN);
  localparam int unsigned CAP = LIMIT + 1;
  localparam int CW = $clog2(CAP + 1);

  logic [PW-1:0] pos_q;
  logic          ref_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          first;

  always_comb begin
    first   = (pos_q == '0);
    win_end = vld && (pos_q == PW'(WIN - 1));
    if (first) cnt_d = CW'(1);
    else       cnt_d = CW'(run_next(32'(cnt_q), bit_in == ref_q, 32'(cnt_q), CAP));
    hit = vld && over_limit(32'(cnt_d), LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr) begin
      pos_q <= '0;
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else if (vld) begin
      pos_q <= win_end ? '0 : pos_q + 1'b1;
      if (first) ref_q <= bit_in;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon
  import ehm_pkg::*;
#(
  parameter int unsigned REP_LIMIT       = 42,
  parameter int unsigned APT_WIN         = 1024,
  parameter int unsigned APT_LIMIT       = 711,
  parameter int unsigned TRN_LIMIT       = 32,
  parameter int unsigned STARTUP_WINDOWS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sample_vld,
  input  logic sample_bit,
  output logic startup_done,
  output logic startup_fail,
  output logic cont_fail
);
  localparam int WCW = $clog2(STARTUP_WINDOWS + 1);

  logic   prev_q, have_prev_q;
  logic   rep_hit, trn_hit, apt_hit, win_end;
  logic   any_hit, startup_last;
  phase_e phase_q;
  logic   cont_q;
  logic [WCW-1:0] win_cnt_q;

  ehm_rep_test #(.LIMIT(REP_LIMIT)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr(restart), .vld(sample_vld),
    .bit_in(sample_bit), .prev_bit(prev_q), .have_prev(have_prev_q),
    .hit(rep_hit)
  );

  ehm_trn_test #(.LIMIT(TRN_LIMIT)) u_trn (
    .clk(clk), .rst_n(rst_n), .clr(restart), .vld(sample_vld),
    .bit_in(sample_bit), .prev_bit(prev_q), .have_prev(have_prev_q),
    .hit(trn_hit)
  );

  ehm_apt_test #(.WIN(APT_WIN), .LIMIT(APT_LIMIT)) u_apt (
    .clk(clk), .rst_n(rst_n), .clr(restart), .vld(sample_vld),
    .bit_in(sample_bit), .hit(apt_hit), .win_end(win_end)
  );

  assign any_hit      = rep_hit | trn_hit | apt_hit;
  assign startup_last = win_end && (win_cnt_q == WCW'(STARTUP_WINDOWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (restart) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (sample_vld) begin
      prev_q      <= sample_bit;
      have_prev_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_STARTUP;
      cont_q    <= 1'b0;
      win_cnt_q <= '0;
    end else if (restart) begin
      phase_q   <= PH_STARTUP;
      cont_q    <= 1'b0;
      win_cnt_q <= '0;
    end else if (sample_vld) begin
      case (phase_q)
        PH_STARTUP: begin
          if (any_hit)           phase_q <= PH_FAILED;
          else if (startup_last) phase_q <= PH_PASSED;
          if (win_end && !startup_last) win_cnt_q <= win_cnt_q + 1'b1;
        end
        PH_PASSED: if (any_hit) cont_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign startup_done = (phase_q == PH_PASSED);
  assign startup_fail = (phase_q == PH_FAILED);
  assign cont_fail    = cont_q;
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic sample_vld,
  input logic startup_done,
  input logic startup_fail,
  input logic cont_fail,
  input logic any_hit,
  input logic win_end
);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !startup_done && !startup_fail && !cont_fail);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(startup_done && startup_fail));

  p_cont_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cont_fail |-> startup_done);

  p_sticky_startup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    startup_fail && !restart |=> startup_fail);

  p_sticky_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cont_fail && !restart |=> cont_fail);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld && !restart |=>
      $stable(startup_done) && $stable(startup_fail) && $stable(cont_fail));

  p_fail_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && any_hit && !restart && !startup_done |=> startup_fail);

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && !startup_done |=> !startup_done || $past(win_end));
endmodule

bind entropy_health_mon ehm_checker u_ehm_checker (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sample_vld(sample_vld),
  .startup_done(startup_done), .startup_fail(startup_fail),
  .cont_fail(cont_fail), .any_hit(any_hit), .win_end(win_end)
);

// File: tb/tb_entropy_health_mon.sv
module tb_entropy_health_mon;
  localparam int unsigned REP = 6;
  localparam int unsigned WIN = 32;
  localparam int unsigned APL = 20;
  localparam int unsigned TRN = 5;
  localparam int unsigned SWN = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic sample_vld = 1'b0;
  logic sample_bit = 1'b0;
  logic startup_done, startup_fail, cont_fail;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int cyc = 0;

  // bench reference state
  int  m_run, m_alt, m_pos, m_cnt, m_win, m_phase;
  bit  m_prev, m_hp, m_ref, m_cf;

  always #2.5 clk = ~clk;

  entropy_health_mon #(.REP_LIMIT(REP), .APT_WIN(WIN), .APT_LIMIT(APL),
                       .TRN_LIMIT(TRN), .STARTUP_WINDOWS(SWN)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sample_vld(sample_vld),
    .sample_bit(sample_bit), .startup_done(startup_done),
    .startup_fail(startup_fail), .cont_fail(cont_fail)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit exp_done(); return m_phase == 1; endfunction
  function automatic bit exp_sfail(); return m_phase == 2; endfunction

  task automatic chk_all(string req);
    chk({req, " done"}, startup_done, exp_done());
    chk({req, " sfail"}, startup_fail, exp_sfail());
    chk({req, " cfail"}, cont_fail, m_cf);
  endtask

  task automatic model_clear();
    m_run = 0; m_alt = 0; m_pos = 0; m_cnt = 0; m_win = 0; m_phase = 0;
    m_prev = 0; m_hp = 0; m_ref = 0; m_cf = 0;
  endtask

  task automatic model_step(bit b);
    int  nr, na, nc;
    bit  first, hit, wend;
    nr = (m_hp && b == m_prev) ? m_run + 1 : 1;
    na = (m_hp && b != m_prev) ? m_alt + 1 : 0;
    first = (m_pos == 0);
    nc = first ? 1 : ((b == m_ref) ? m_cnt + 1 : m_cnt);
    hit = (nr > REP) || (na > TRN) || (nc > APL);
    wend = (m_pos == WIN - 1);
    if (m_phase == 0) begin
      if (hit) m_phase = 2;
      else if (wend && m_win == SWN - 1) m_phase = 1;
      if (wend) m_win++;
    end else if (m_phase == 1 && hit) m_cf = 1;
    if (first) m_ref = b;
    m_run = nr; m_alt = na; m_cnt = nc;
    m_pos = wend ? 0 : m_pos + 1;
    m_prev = b; m_hp = 1;
  endtask

  // drive one valid sample; returns after the taking edge
  task automatic send(bit b);
    @(negedge clk);
    sample_vld = 1'b1;
    sample_bit = b;
    model_step(b);
    @(posedge clk);
    #1;
    sample_vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_vld = 1'b0;
      sample_bit = ~sample_bit;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    sample_vld = 1'b0;
    model_clear();
    @(posedge clk);
    #1;
    restart = 1'b0;
  endtask

  task automatic send_pass_window();
    for (int i = 0; i < int'(WIN); i++) send(i[1]);   // 0011 pattern
  endtask

  initial begin
    bit b;
    void'($urandom(32'd4242));
    model_clear();
    #1;
    chk("R1 reset done", startup_done, 1'b0);
    chk("R1 reset sfail", startup_fail, 1'b0);
    chk("R1 reset cfail", cont_fail, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_all("R1 after reset");

    // R5: startup passes exactly after the last sample of the window
    for (int i = 0; i < int'(WIN) - 1; i++) send(i[1]);
    chk("R5 before last sample", startup_done, 1'b0);
    send(1'b1);
    chk("R5 after last sample", startup_done, 1'b1);
    chk_all("R5 model");

    // R8 + R2 + R7: run of REP zeros split by idle cycles, then one more
    for (int i = 0; i < int'(REP); i++) begin
      send(1'b0);
      idle(2);
    end
    chk("R2 run at limit", cont_fail, 1'b0);
    chk("R8 idle keeps run", startup_done, 1'b1);
    @(negedge clk);
    sample_vld = 1'b1; sample_bit = 1'b0;
    model_step(1'b0);
    #1 chk("R10 before edge", cont_fail, 1'b0);
    @(posedge clk); #1 sample_vld = 1'b0;
    chk("R2 run past limit", cont_fail, 1'b1);
    chk("R7 done stays", startup_done, 1'b1);
    chk("R7 sfail stays low", startup_fail, 1'b0);
    idle(5);
    chk_all("R8 idle after fail");

    // R9 + R4: alternation boundary during startup
    do_restart();
    chk_all("R9 cleared");
    chk("R1 restart clears", cont_fail, 1'b0);
    for (int i = 0; i <= int'(TRN); i++) send(i[0]);
    chk("R4 alternation at limit", startup_fail, 1'b0);
    send(TRN[0] ^ 1'b1);
    chk("R4 alternation past limit", startup_fail, 1'b1);
    for (int i = 0; i < 40; i++) send(i[1]);
    chk("R6 done blocked", startup_done, 1'b0);
    chk("R6 fail sticky", startup_fail, 1'b1);

    // R3: window with exactly APL reference values passes
    do_restart();
    for (int i = 0; i < 10; i++) begin send(0); send(0); send(1); end
    send(1); send(1);
    chk("R3 count at limit", startup_fail, 1'b0);
    chk("R3 pass done", startup_done, 1'b1);

    // R3: APL+1 reference values fails on the offending sample
    do_restart();
    for (int i = 0; i < 10; i++) begin send(0); send(0); send(1); end
    chk("R3 before extra ref", startup_fail, 1'b0);
    send(0);
    chk("R3 count past limit", startup_fail, 1'b1);
    chk_all("R3 model");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      do_restart();
      chk_all("R9 random restart");
      b = 1'b0;
      for (int i = 0; i < 120; i++) begin
        case ($urandom % 4)
          0:       b = ~b;
          1:       b = b;
          default: b = $urandom % 2;
        endcase
        send(b);
        if (($urandom % 8) == 0) idle(1 + $urandom % 3);
        chk_all("R2 R3 R4 R5 R7 random");
      end
    end
    report();
  end
endmodule